// File: doc/BRIEF.md
# Frame Timeslot Type Classifier

This block follows the bit position inside a serial time-division frame and tells the surrounding logic what kind of traffic the current 8-bit timeslot carries. A position counter steps once for every bit period marked by `bit_en` and wraps at a frame length set by the host. A sampled frame pulse realigns the counter to a host-set offset. The counter's upper bits select the timeslot index.

Each timeslot index is looked up in two assignment tables, one for the transmit side and one for the receive side. Each table holds a 2-bit type per timeslot, packed sixteen to a 32-bit host word. Host writes go into a staging copy. The staging copy moves into the live copy only when the counter restarts a frame, so a frame never sees a mix of old and new assignments. Downstream logic uses the timeslot strobe and the two type outputs to steer each slot's bits to voice, HDLC or 56K handling, or to drop them.

Top module: `tslot_classifier`

## Requirements
- R1: While reset is held, and right after it is released, `bit_pos` is 0, `slot_strobe` and `frame_start` are 0, and every entry of both tables is 00, so both type outputs read 00.
- R2: On each clock edge where `bit_en` is 1 and no restart happens, `bit_pos` goes up by one. When `bit_en` is 0, `bit_pos` holds its value.
- R3: When `bit_en` is 1, `frame_pulse` is 0 and `bit_pos` is at or beyond the effective length minus 1, `bit_pos` goes to 0. The effective length is `cfg_frame_len`, except that 0 or any value above 1024 means 1024.
- R4: A frame pulse is sampled only on an edge with `bit_en` high. A sampled pulse loads `cfg_pulse_ofs` into `bit_pos`, or loads 0 if the offset is not below the effective length. A pulse while `bit_en` is low has no effect.
- R5: `slot_idx` always equals `bit_pos` divided by 8 (its bits 9:3).
- R6: `slot_strobe` is high for exactly the cycle after an advancing edge (one with `bit_en` high) that leaves `bit_pos` at a multiple of 8. It is low otherwise.
- R7: `frame_start` is high for exactly the cycle after an edge that restarted the counter, either by a wrap (R3) or by a sampled pulse (R4).
- R8: The tables are laid out as follows. Word k (`tbl_wr_word`) holds timeslots 16k to 16k+15. Bits 2j+1:2j of the word hold timeslot 16k+j. Type codes are 00 unassigned, 01 voice, 10 HDLC and 11 56K mode. `tx_slot_type` shows the entry of the TX table (`tbl_wr_rx`=0) for `slot_idx`. `rx_slot_type` shows the entry of the RX table (`tbl_wr_rx`=1).
- R9: A table write is staged and becomes visible at the first counter restart after it. The new types appear in the same cycle that `frame_start` is high. A write made on the restart edge itself waits for the next restart. Between restarts, the type outputs change only when `slot_idx` changes.
- R10: A write to one table leaves the other table's entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit period has elapsed |
| frame_pulse | input | 1 | Frame alignment pulse, sampled with bit_en |
| cfg_frame_len | input | 11 | Frame length in bits (0 or above 1024 means 1024) |
| cfg_pulse_ofs | input | 10 | Bit position loaded on a sampled frame pulse |
| tbl_wr_en | input | 1 | Host table write strobe |
| tbl_wr_rx | input | 1 | Table select: 0 TX, 1 RX |
| tbl_wr_word | input | 3 | Table word index |
| tbl_wr_data | input | 32 | Sixteen packed 2-bit timeslot types |
| bit_pos | output | 10 | Current bit position in the frame |
| slot_idx | output | 7 | Current timeslot index |
| slot_strobe | output | 1 | First bit of a timeslot reached |
| frame_start | output | 1 | Counter restarted a frame; new table contents live |
| tx_slot_type | output | 2 | TX type of the current timeslot |
| rx_slot_type | output | 2 | RX type of the current timeslot |

## Verification
The bench targets several corner cases:
- A write that should stay hidden until a restart. A design that copied the table at once would show new types in the middle of a frame.
- A write on the restart edge itself. A design with the wrong priority would expose that write one frame early.
- A frame length of 0 and of 1024, which must both wrap after position 1023. A design that narrowed the compare would wrap early or never.
- An offset at or above a short frame length, and a pulse while `bit_en` is low. A design that got these wrong would jump outside the frame or realign without a bit period.
- Frame lengths that are not multiples of 8. These expose a strobe that depends on the slot counter rather than on the bit position.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   typedef enum logic [1:0] {
      SLOT_UNUSED = 2'b00,
      SLOT_VOICE  = 2'b01,
      SLOT_HDLC   = 2'b10,
      SLOT_56K    = 2'b11
   } slot_type_e;

   localparam int DIR_TX = 0;
   localparam int DIR_RX = 1;
   localparam int N_DIR  = 2;

endpackage

// File: rtl/tsc_bit_counter.sv
module tsc_bit_counter #(
   parameter int POS_W     = 10,
   parameter int LEN_W     = 11,
   parameter int SUB_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             frame_pulse,
   input  logic [LEN_W-1:0] eff_len,
   input  logic [POS_W-1:0] pulse_ofs,
   output logic [POS_W-1:0] pos,
   output logic             restart,
   output logic             slot_strobe,
   output logic             frame_start
);

   logic [POS_W-1:0] nxt_pos;
   logic             ofs_fits;
   logic             at_end;

   assign ofs_fits = ({1'b0, pulse_ofs} < eff_len);
   assign at_end   = ({1'b0, pos} >= (eff_len - 1'b1));

   always_comb begin
      nxt_pos = pos;
      restart = 1'b0;
      if (bit_en) begin
         if (frame_pulse) begin
            restart = 1'b1;
            nxt_pos = ofs_fits ? pulse_ofs : '0;
         end else if (at_end) begin
            restart = 1'b1;
            nxt_pos = '0;
         end else begin
            nxt_pos = pos + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos         <= '0;
         slot_strobe <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         pos         <= nxt_pos;
         slot_strobe <= bit_en && (nxt_pos[SUB_W-1:0] == '0);
         frame_start <= restart;
      end
   end

endmodule

// File: rtl/tsc_slot_table.sv
module tsc_slot_table #(
   parameter int NSLOTS    = 128,
   parameter int TYPE_W    = 2,
   parameter int HOST_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int SLOT_W    = 7,
   parameter bit SHADOW_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_word,
   input  logic [HOST_W-1:0] wr_data,
   input  logic              commit,
   input  logic [SLOT_W-1:0] rd_idx,
   output logic [TYPE_W-1:0] rd_type
);

   localparam int TBL_BITS = NSLOTS * TYPE_W;

   logic [TBL_BITS-1:0] live_q;

   if (SHADOW_EN) begin : g_staged
      logic [TBL_BITS-1:0] stage_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
         end else begin
            if (commit)
               live_q <= stage_q;
            if (wr_en)
               stage_q[wr_word*HOST_W +: HOST_W] <= wr_data;
         end
      end
   end else begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n)
            live_q <= '0;
         else if (wr_en)
            live_q[wr_word*HOST_W +: HOST_W] <= wr_data;
      end
   end

   assign rd_type = live_q[rd_idx*TYPE_W +: TYPE_W];

endmodule

// File: rtl/tslot_classifier.sv
module tslot_classifier
   import tsc_pkg::*;
#(
   parameter int MAX_FRAME_BITS = 1024,
   parameter int SLOT_BITS      = 8,
   parameter int TYPE_W         = 2,
   parameter int HOST_W         = 32,
   parameter bit SHADOW_EN      = 1'b1,
   localparam int POS_W   = $clog2(MAX_FRAME_BITS),
   localparam int LEN_W   = POS_W + 1,
   localparam int SUB_W   = $clog2(SLOT_BITS),
   localparam int NSLOTS  = MAX_FRAME_BITS / SLOT_BITS,
   localparam int SLOT_W  = $clog2(NSLOTS),
   localparam int PER_WRD = HOST_W / TYPE_W,
   localparam int NWORDS  = NSLOTS / PER_WRD,
   localparam int ADDR_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              frame_pulse,
   input  logic [LEN_W-1:0]  cfg_frame_len,
   input  logic [POS_W-1:0]  cfg_pulse_ofs,
   input  logic              tbl_wr_en,
   input  logic              tbl_wr_rx,
   input  logic [ADDR_W-1:0] tbl_wr_word,
   input  logic [HOST_W-1:0] tbl_wr_data,
   output logic [POS_W-1:0]  bit_pos,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              slot_strobe,
   output logic              frame_start,
   output logic [TYPE_W-1:0] tx_slot_type,
   output logic [TYPE_W-1:0] rx_slot_type
);

   initial begin
      assert (MAX_FRAME_BITS == (1 << POS_W))
         else $error("MAX_FRAME_BITS must be a power of two");
      assert (SLOT_BITS == (1 << SUB_W))
         else $error("SLOT_BITS must be a power of two");
      assert (HOST_W % TYPE_W == 0)
         else $error("HOST_W must hold a whole number of entries");
      assert (NSLOTS % PER_WRD == 0)
         else $error("table must fill a whole number of host words");
   end

   logic [LEN_W-1:0]  eff_len;
   logic              restart;
   logic [TYPE_W-1:0] dir_type [N_DIR];

   assign eff_len = ((cfg_frame_len == '0) || (cfg_frame_len > LEN_W'(MAX_FRAME_BITS)))
                    ? LEN_W'(MAX_FRAME_BITS) : cfg_frame_len;

   tsc_bit_counter #(
      .POS_W (POS_W),
      .LEN_W (LEN_W),
      .SUB_W (SUB_W)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .frame_pulse (frame_pulse),
      .eff_len     (eff_len),
      .pulse_ofs   (cfg_pulse_ofs),
      .pos         (bit_pos),
      .restart     (restart),
      .slot_strobe (slot_strobe),
      .frame_start (frame_start)
   );

   assign slot_idx = bit_pos[POS_W-1:SUB_W];

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      logic sel;
      assign sel = tbl_wr_en && (tbl_wr_rx == d[0]);

      tsc_slot_table #(
         .NSLOTS    (NSLOTS),
         .TYPE_W    (TYPE_W),
         .HOST_W    (HOST_W),
         .ADDR_W    (ADDR_W),
         .SLOT_W    (SLOT_W),
         .SHADOW_EN (SHADOW_EN)
      ) u_tbl (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (sel),
         .wr_word (tbl_wr_word),
         .wr_data (tbl_wr_data),
         .commit  (restart),
         .rd_idx  (slot_idx),
         .rd_type (dir_type[d])
      );
   end

   assign tx_slot_type = dir_type[DIR_TX];
   assign rx_slot_type = dir_type[DIR_RX];

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int POS_W     = 10,
   parameter int SLOT_W    = 7,
   parameter int SUB_W     = 3,
   parameter int TYPE_W    = 2,
   parameter bit SHADOW_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              frame_pulse,
   input logic [POS_W-1:0]  bit_pos,
   input logic [SLOT_W-1:0] slot_idx,
   input logic              slot_strobe,
   input logic              frame_start,
   input logic [TYPE_W-1:0] tx_slot_type,
   input logic [TYPE_W-1:0] rx_slot_type
);

   // R2: position frozen without a bit period
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(bit_pos));

   // R2 and R3: an unpulsed step is +1 or a wrap to 0
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !frame_pulse) |=> ((bit_pos == $past(bit_pos) + 1'b1) || (bit_pos == '0)));

   // R4: a restart landing away from 0 was caused by a sampled pulse
   a_r4_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && (bit_pos != '0)) |-> $past(frame_pulse && bit_en));

   // R6: strobe only on a slot's first bit
   a_r6_strobe_align: assert property (@(posedge clk) disable iff (!rst_n)
      slot_strobe |-> (bit_pos[SUB_W-1:0] == '0));

   // R7: a restart needs a bit period
   a_r7_start_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> $past(bit_en));

   if (SHADOW_EN) begin : g_frame_atomic
      // R9: types change only with the slot or at a restart
      a_r9_types_steady: assert property (@(posedge clk) disable iff (!rst_n)
         (!frame_start && $stable(slot_idx)) |-> ($stable(tx_slot_type) && $stable(rx_slot_type)));
   end

endmodule

bind tslot_classifier tsc_checker #(
   .POS_W     (POS_W),
   .SLOT_W    (SLOT_W),
   .SUB_W     (SUB_W),
   .TYPE_W    (TYPE_W),
   .SHADOW_EN (SHADOW_EN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bit_en       (bit_en),
   .frame_pulse  (frame_pulse),
   .bit_pos      (bit_pos),
   .slot_idx     (slot_idx),
   .slot_strobe  (slot_strobe),
   .frame_start  (frame_start),
   .tx_slot_type (tx_slot_type),
   .rx_slot_type (rx_slot_type)
);

// File: tb/tslot_classifier_tb.sv
`timescale 1ns/1ps
module tslot_classifier_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        frame_pulse = 1'b0;
   logic [10:0] cfg_frame_len = '0;
   logic [9:0]  cfg_pulse_ofs = '0;
   logic        tbl_wr_en = 1'b0;
   logic        tbl_wr_rx = 1'b0;
   logic [2:0]  tbl_wr_word = '0;
   logic [31:0] tbl_wr_data = '0;
   logic [9:0]  bit_pos;
   logic [6:0]  slot_idx;
   logic        slot_strobe;
   logic        frame_start;
   logic [1:0]  tx_slot_type;
   logic [1:0]  rx_slot_type;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [255:0] m_stage [2];
   logic [255:0] m_live  [2];
   int  m_pos;
   int  m_len;
   int  m_ofs;
   bit  e_strobe;
   bit  e_fs;
   int  n_len;
   int  n_ofs;

   always #5 clk = ~clk;

   tslot_classifier u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_en        (bit_en),
      .frame_pulse   (frame_pulse),
      .cfg_frame_len (cfg_frame_len),
      .cfg_pulse_ofs (cfg_pulse_ofs),
      .tbl_wr_en     (tbl_wr_en),
      .tbl_wr_rx     (tbl_wr_rx),
      .tbl_wr_word   (tbl_wr_word),
      .tbl_wr_data   (tbl_wr_data),
      .bit_pos       (bit_pos),
      .slot_idx      (slot_idx),
      .slot_strobe   (slot_strobe),
      .frame_start   (frame_start),
      .tx_slot_type  (tx_slot_type),
      .rx_slot_type  (rx_slot_type)
   );

   function automatic int eff_len_f(input int len);
      return (len == 0 || len > 1024) ? 1024 : len;
   endfunction

   function automatic int exp_type(input int dir, input int pos);
      return int'(m_live[dir][(pos / 8) * 2 +: 2]);
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "bit_pos", int'(bit_pos), m_pos);
      chk("R5", "slot_idx", int'(slot_idx), m_pos / 8);
      chk("R6", "slot_strobe", int'(slot_strobe), int'(e_strobe));
      chk("R7", "frame_start", int'(frame_start), int'(e_fs));
      chk("R8 R9 R10", "tx_slot_type", int'(tx_slot_type), exp_type(0, m_pos));
      chk("R8 R9 R10", "rx_slot_type", int'(rx_slot_type), exp_type(1, m_pos));
   endtask

   task automatic model_next(input bit en, input bit pl, input bit wr, input bit wrrx,
                             input int wd, input logic [31:0] dat);
      int el;
      int np;
      bit rs;
      el = eff_len_f(m_len);
      np = m_pos;
      rs = 1'b0;
      if (en) begin
         if (pl) begin
            rs = 1'b1;
            np = (m_ofs < el) ? m_ofs : 0;
         end else if (m_pos >= el - 1) begin
            rs = 1'b1;
            np = 0;
         end else begin
            np = m_pos + 1;
         end
      end
      if (rs) begin
         m_live[0] = m_stage[0];
         m_live[1] = m_stage[1];
      end
      if (wr) m_stage[wrrx][wd * 32 +: 32] = dat;
      e_strobe = en && ((np % 8) == 0);
      e_fs     = rs;
      m_pos    = np;
   endtask

   // check outputs, then drive one clock's worth of inputs and advance the model
   task automatic cycle(input string tag, input bit en, input bit pl, input bit wr,
                        input bit wrrx, input int wd, input logic [31:0] dat);
      @(negedge clk);
      check_all(tag);
      cfg_frame_len = 11'(n_len);
      cfg_pulse_ofs = 10'(n_ofs);
      m_len = n_len;
      m_ofs = n_ofs;
      bit_en = en;
      frame_pulse = pl;
      tbl_wr_en = wr;
      tbl_wr_rx = wrrx;
      tbl_wr_word = 3'(wd);
      tbl_wr_data = dat;
      model_next(en, pl, wr, wrrx, wd, dat);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired, actual running expected done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      m_stage[0] = '0; m_stage[1] = '0;
      m_live[0]  = '0; m_live[1]  = '0;
      m_pos = 0; m_len = 0; m_ofs = 0; n_len = 0; n_ofs = 0;
      e_strobe = 1'b0; e_fs = 1'b0;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "bit_pos", int'(bit_pos), 0);
      chk("R1", "slot_strobe", int'(slot_strobe), 0);
      chk("R1", "frame_start", int'(frame_start), 0);
      chk("R1", "tx_slot_type", int'(tx_slot_type), 0);
      chk("R1", "rx_slot_type", int'(rx_slot_type), 0);
      rst_n = 1'b1;

      // R9: staged writes stay hidden until a restart; R10 separate tables
      n_len = 1024; n_ofs = 0;
      cycle("R2", 1'b1, 1'b0, 1'b1, 1'b0, 0, 32'hE4E4_E4E4);
      cycle("R2", 1'b1, 1'b0, 1'b1, 1'b1, 0, 32'h1B1B_1B1B);
      for (int i = 0; i < 40; i++) cycle("R2", 1'b1, 1'b0, 1'b0, 1'b0, 0, '0);
      // pulse to offset 0 commits; write on that same edge waits another frame
      cycle("R4", 1'b1, 1'b1, 1'b1, 1'b0, 0, 32'hFFFF_FFFF);
      for (int i = 0; i < 60; i++) cycle("R2", 1'b1, 1'b0, 1'b0, 1'b0, 0, '0);
      cycle("R4", 1'b1, 1'b1, 1'b0, 1'b0, 0, '0);
      for (int i = 0; i < 20; i++) cycle("R2", 1'b1, 1'b0, 1'b0, 1'b0, 0, '0);

      // R3: length 0 means 1024, full wrap
      n_len = 0;
      for (int i = 0; i < 1100; i++) cycle("R3", 1'b1, 1'b0, 1'b0, 1'b0, 0, '0);

      // R4: offset beyond a short frame loads 0; R3 wrap of a 20-bit frame
      n_len = 20; n_ofs = 25;
      cycle("R4", 1'b1, 1'b1, 1'b0, 1'b0, 0, '0);
      for (int i = 0; i < 50; i++) cycle("R3", 1'b1, 1'b0, 1'b0, 1'b0, 0, '0);

      // R4: pulse without a bit period is ignored; R2 hold
      n_ofs = 7;
      for (int i = 0; i < 5; i++) cycle("R4", 1'b0, 1'b1, 1'b0, 1'b0, 0, '0);
      cycle("R4", 1'b1, 1'b1, 1'b0, 1'b0, 0, '0);
      for (int i = 0; i < 10; i++) cycle("R2", 1'b1, 1'b0, 1'b0, 1'b0, 0, '0);

      // constrained random: R2 R3 R4 R6 R7 R8 R9 R10
      for (int ph = 0; ph < 8; ph++) begin
         int pick;
         pick = int'($urandom_range(0, 9));
         if (pick == 0) n_len = 0;
         else if (pick == 1) n_len = 1024;
         else if (pick == 2) n_len = 1100;
         else n_len = int'($urandom_range(1, 300));
         n_ofs = int'($urandom_range(0, 1023));
         if (pick > 5) n_ofs = n_ofs % (n_len + 8);
         for (int i = 0; i < 1800; i++) begin
            bit en, pl, wr, wrrx;
            en   = ($urandom_range(0, 99) < 75);
            pl   = ($urandom_range(0, 199) == 0);
            wr   = ($urandom_range(0, 99) < 4);
            wrrx = $urandom_range(0, 1) == 1;
            cycle("R2 R3 R4", en, pl, wr, wrrx, int'($urandom_range(0, 7)), $urandom());
         end
      end

      @(negedge clk);
      check_all("R2 R3 R4");
      finish_run();
   end

endmodule